// File: doc/BRIEF.md
# Phase Comparator Lock Monitor

This block sits behind a phase-frequency comparator and decides whether the loop it belongs to has settled. On every comparison cycle it measures how long exactly one of the two correction pulses (advance and retard) is high, counting in fast-clock ticks. That tick count is the phase error of the cycle. A comparison cycle closes on the first tick in which both pulses are low. The next cycle opens on the next tick in which either pulse is high.

The lock flag is active high and has hysteresis. While the flag is low, the block counts how many comparison cycles in a row showed an error below the entry threshold. It raises the flag once that run reaches three cycles, or five cycles when the precision input is set. While the flag is high, a single cycle whose error is above the exit threshold clears it. Errors between the two thresholds do not change the flag. Both thresholds are input ports in ticks. With a 1 ns tick, values of 15 and 25 give the usual 15 ns / 25 ns behaviour.

There is no data stream, so there is no valid/ready handshake. All pins are plain control or status pins, sampled on the rising clock edge. The pulse inputs are expected to be synchronous to the tick clock.

Top module: `lockdet_top`

## Requirements
- R1: Reset (rst_n low) drives lock_o low and clears the run of good cycles, so after reset a full run is needed again.
- R2: A cycle's error is the number of sampled ticks with up_i != dn_i, counted from the first tick with either pulse high up to the first tick with both low. The count saturates at 2^ERR_W-1 and does not wrap.
- R3: With prec_i = 0 and lock_o low, lock_o rises after 3 consecutive comparison cycles with error < thr_enter_i.
- R4: With prec_i = 1 and lock_o low, lock_o rises only after 5 consecutive comparison cycles with error < thr_enter_i.
- R5: While lock_o is low, a cycle with error >= thr_enter_i resets the run of good cycles to zero.
- R6: While lock_o is high, one cycle with error > thr_exit_i drives lock_o low, and the run restarts from zero.
- R7: While lock_o is high, a cycle with error <= thr_exit_i, including errors between the two thresholds, leaves lock_o high.
- R8: Consider the first rising edge that samples both pulses low. lock_o reacts to the cycle that edge closes on the second rising edge after it.
- R9: A new comparison cycle may open on the tick right after a single idle tick. Its error is measured on its own, while the previous cycle is still being judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_i | input | 1 | Advance pulse from the comparator |
| dn_i | input | 1 | Retard pulse from the comparator |
| prec_i | input | 1 | 0: run of 3 good cycles, 1: run of 5 |
| thr_enter_i | input | ERR_W | Entry threshold in ticks (good if error < this) |
| thr_exit_i | input | ERR_W | Exit threshold in ticks (lose lock if error > this) |
| lock_o | output | 1 | Lock flag, active high |

## Verification
Two things can happen in the same clock. The measuring stage can open a new comparison cycle while the judging stage is still consuming the error of the cycle that just closed. The bench provokes this by sending pulse pairs separated by one idle tick. It judges the result by two checks: the lock flag must still be low one tick after the third pulse pair closes, and it must be high one tick later. This shows that neither cycle's error leaked into the other, and that the two-edge latency holds under back-to-back traffic.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  typedef enum logic {
    LK_SEARCH = 1'b0,
    LK_HELD   = 1'b1
  } lk_state_e;

  // saturating increment used by the error meter
  function automatic logic [15:0] sat_step(input logic [15:0] v, input logic [15:0] top);
    return (v >= top) ? top : v + 16'd1;
  endfunction

endpackage

// File: rtl/lockdet_meter.sv
module lockdet_meter #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_i,
  input  logic             dn_i,
  output logic             done_o,
  output logic [ERR_W-1:0] err_o
);
  import lockdet_pkg::*;

  localparam logic [ERR_W-1:0] ERR_TOP = {ERR_W{1'b1}};

  logic             open_q;
  logic [ERR_W-1:0] acc_q;
  logic             done_q;
  logic [ERR_W-1:0] err_q;
  logic             any_hi;
  logic             one_hi;
  logic [15:0]      acc_nx;

  assign any_hi = up_i | dn_i;
  assign one_hi = up_i ^ dn_i;
  assign acc_nx = sat_step(16'(acc_q), 16'(ERR_TOP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      acc_q  <= '0;
      done_q <= 1'b0;
      err_q  <= '0;
    end else if (any_hi) begin
      open_q <= 1'b1;
      done_q <= 1'b0;
      if (one_hi) acc_q <= acc_nx[ERR_W-1:0];
    end else if (open_q) begin
      // first idle tick closes the comparison cycle
      open_q <= 1'b0;
      done_q <= 1'b1;
      err_q  <= acc_q;
      acc_q  <= '0;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  // R2: a closing strobe lasts one tick
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: a strobe only follows an idle tick that closed an open cycle
  assert_done_after_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(open_q && !any_hi));

endmodule

// File: rtl/lockdet_cmp.sv
module lockdet_cmp #(
  parameter int ERR_W = 8
) (
  input  logic [ERR_W-1:0] err_i,
  input  logic [ERR_W-1:0] thr_enter_i,
  input  logic [ERR_W-1:0] thr_exit_i,
  output logic             good_o,
  output logic             bad_o
);

  always_comb begin
    good_o = (err_i < thr_enter_i);
    bad_o  = (err_i > thr_exit_i);
  end

endmodule

// File: rtl/lockdet_fsm.sv
module lockdet_fsm #(
  parameter int RUN_LO = 3,
  parameter int RUN_HI = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic good_i,
  input  logic bad_i,
  input  logic prec_i,
  output logic lock_o
);
  import lockdet_pkg::*;

  localparam int RUN_W = $clog2(RUN_HI + 1);

  lk_state_e        st_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] need;
  logic [RUN_W:0]   run_nx;

  assign need   = prec_i ? RUN_W'(RUN_HI) : RUN_W'(RUN_LO);
  assign run_nx = {1'b0, run_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= LK_SEARCH;
      run_q <= '0;
    end else if (done_i) begin
      unique case (st_q)
        LK_SEARCH: begin
          if (!good_i) begin
            run_q <= '0;
          end else if (run_nx >= {1'b0, need}) begin
            st_q  <= LK_HELD;
            run_q <= '0;
          end else begin
            run_q <= run_nx[RUN_W-1:0];
          end
        end
        LK_HELD: begin
          if (bad_i) begin
            st_q  <= LK_SEARCH;
            run_q <= '0;
          end
        end
        default: st_q <= LK_SEARCH;
      endcase
    end
  end

  assign lock_o = (st_q == LK_HELD);

  // R3 / R4: lock only rises right after a good closing cycle
  assert_lock_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(done_i && good_i));

  // R4: the run never reaches the longer limit while searching
  assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < RUN_W'(RUN_HI));

  // R5: a poor cycle while searching empties the run
  assert_run_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && done_i && !good_i) |=> (run_q == '0 && !lock_o));

  // R6: lock only falls right after a bad closing cycle
  assert_lock_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> $past(done_i && bad_i));

  // R7: a tolerable cycle keeps lock
  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && done_i && !bad_i) |=> lock_o);

  // R8: outside closing strobes the flag is steady
  assert_lock_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(lock_o));

endmodule

// File: rtl/lockdet_top.sv
module lockdet_top #(
  parameter int ERR_W  = 8,
  parameter int RUN_LO = 3,
  parameter int RUN_HI = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             prec_i,
  input  logic [ERR_W-1:0] thr_enter_i,
  input  logic [ERR_W-1:0] thr_exit_i,
  output logic             lock_o
);

  logic             done;
  logic [ERR_W-1:0] err;
  logic             good;
  logic             bad;

  lockdet_meter #(.ERR_W(ERR_W)) meter_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_i   (up_i),
    .dn_i   (dn_i),
    .done_o (done),
    .err_o  (err)
  );

  lockdet_cmp #(.ERR_W(ERR_W)) cmp_i (
    .err_i       (err),
    .thr_enter_i (thr_enter_i),
    .thr_exit_i  (thr_exit_i),
    .good_o      (good),
    .bad_o       (bad)
  );

  lockdet_fsm #(.RUN_LO(RUN_LO), .RUN_HI(RUN_HI)) fsm_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .done_i (done),
    .good_i (good),
    .bad_i  (bad),
    .prec_i (prec_i),
    .lock_o (lock_o)
  );

  // R1: flag is low on the first tick after reset
  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> !lock_o);

endmodule

// File: tb/lockdet_top_tb.sv
`timescale 1ns/1ps
module lockdet_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up = 1'b0;
  logic       dn = 1'b0;
  logic       prec = 1'b0;
  logic [7:0] thr_in = 8'd15;
  logic [7:0] thr_out = 8'd25;
  logic       lock;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  lockdet_top dut_i (
    .clk(clk), .rst_n(rst_n), .up_i(up), .dn_i(dn), .prec_i(prec),
    .thr_enter_i(thr_in), .thr_exit_i(thr_out), .lock_o(lock)
  );

  // {prec, up ticks, down ticks, expected lock}; both pulses rise together
  localparam int NV = 18;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 8'd4,  8'd4,  1'b0},  // R3 good 1
    {1'b0, 8'd10, 8'd24, 1'b0},  // R3 err 14 good 2
    {1'b0, 8'd2,  8'd2,  1'b1},  // R3 third -> lock
    {1'b0, 8'd30, 8'd5,  1'b1},  // R7 err 25 keeps
    {1'b0, 8'd2,  8'd28, 1'b0},  // R6 err 26 drops
    {1'b1, 8'd3,  8'd3,  1'b0},  // R4 run 1
    {1'b1, 8'd3,  8'd3,  1'b0},  // R4 run 2
    {1'b1, 8'd20, 8'd5,  1'b0},  // R5 err 15 clears
    {1'b1, 8'd3,  8'd3,  1'b0},  // R4 run 1
    {1'b1, 8'd3,  8'd3,  1'b0},  // R4 run 2
    {1'b1, 8'd3,  8'd3,  1'b0},  // R4 run 3
    {1'b1, 8'd3,  8'd3,  1'b0},  // R4 run 4
    {1'b1, 8'd3,  8'd3,  1'b1},  // R4 run 5 -> lock
    {1'b1, 8'd40, 8'd20, 1'b1},  // R7 err 20 between thresholds
    {1'b1, 8'd1,  8'd30, 1'b0},  // R6 err 29 drops
    {1'b0, 8'd6,  8'd9,  1'b0},  // R6 run restarts
    {1'b0, 8'd6,  8'd9,  1'b0},
    {1'b0, 8'd6,  8'd9,  1'b1}   // R3 lock again
  };

  task automatic check(input logic exp, input string tag);
    total++;
    if (lock !== exp) begin
      bad++;
      $display("FAIL %s: lock=%0b expected=%0b", tag, lock, exp);
    end
  endtask

  // starts at a falling edge; leaves both pulses low at a falling edge
  task automatic pulse(input int a, input int b, input int dn_lead);
    int span;
    span = (a > dn_lead + b) ? a : dn_lead + b;
    for (int i = 0; i < span; i++) begin
      up = (i < a);
      dn = (i >= dn_lead) && (i < dn_lead + b);
      @(negedge clk);
    end
    up = 1'b0;
    dn = 1'b0;
  endtask

  task automatic cycle_chk(input int a, input int b, input int dn_lead,
                           input logic exp, input string tag);
    pulse(a, b, dn_lead);
    @(negedge clk);
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(1'b0, "R1 reset low");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: lock=%0b expected=finish", lock);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    for (int k = 0; k < NV; k++) begin
      prec = VEC[k][17];
      cycle_chk(int'(VEC[k][16:9]), int'(VEC[k][8:1]), 0, VEC[k][0],
                $sformatf("R3/R4/R5/R6/R7 vector %0d", k));
    end

    // R1: reset while locked, then the run must start over
    prec = 1'b0;
    do_reset();
    cycle_chk(2, 2, 0, 1'b0, "R1 run 1");
    cycle_chk(2, 2, 0, 1'b0, "R1 run 2");
    do_reset();
    cycle_chk(2, 2, 0, 1'b0, "R1 run cleared by reset");
    cycle_chk(2, 2, 0, 1'b0, "R1 run 2 after reset");
    cycle_chk(2, 2, 0, 1'b1, "R1 run 3 after reset");

    // R2: staggered pulses count both one-sided stretches
    do_reset();
    cycle_chk(2, 2, 0, 1'b0, "R2 good 1");
    cycle_chk(2, 2, 0, 1'b0, "R2 good 2");
    cycle_chk(10, 16, 5, 1'b0, "R2 stagger err 16 clears run");
    cycle_chk(2, 2, 0, 1'b0, "R2 good 1 again");
    cycle_chk(2, 2, 0, 1'b0, "R2 good 2 again");
    cycle_chk(10, 14, 5, 1'b1, "R2 stagger err 14 is good");

    // R2: saturation, 300 ticks reads 255 which exceeds 254
    thr_out = 8'd254;
    cycle_chk(300, 0, 0, 1'b0, "R2 saturating error drops lock");
    thr_out = 8'd25;

    // R8/R9: back-to-back pairs with one idle tick
    do_reset();
    pulse(3, 3, 0);
    @(negedge clk);
    pulse(3, 3, 0);
    @(negedge clk);
    pulse(3, 3, 0);
    @(negedge clk);
    check(1'b0, "R8 not yet one edge after close");
    @(negedge clk);
    check(1'b1, "R9 back-to-back run locks");

    // R5: threshold comes from the port
    do_reset();
    thr_in = 8'd5;
    cycle_chk(6, 0, 0, 1'b0, "R5 err 6 vs 5 poor");
    cycle_chk(6, 0, 0, 1'b0, "R5 err 6 vs 5 poor");
    cycle_chk(6, 0, 0, 1'b0, "R5 err 6 vs 5 poor");
    cycle_chk(4, 0, 0, 1'b0, "R5 err 4 good 1");
    cycle_chk(4, 0, 0, 1'b0, "R5 err 4 good 2");
    cycle_chk(4, 0, 0, 1'b1, "R5 err 4 good 3 locks");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule